// File: doc/BRIEF.md
# Framed Serial Transmitter with Forwarded Bit Clock

This block turns a byte-wide request stream into a framed serial message on one data wire. It drives a companion clock wire beside the data. The first byte the source offers is a length code. The block then takes exactly as many further bytes as that code asks for: a command byte, then the payload bytes. It computes a CRC8 over everything it has sent and appends it as the last character of the frame.

Each byte goes out as an eleven-bit character. The line idles low, the start bit is high and the stop bit is low, so the polarity is the reverse of the usual asynchronous serial framing. The block runs from a clock at twice the bit rate. It generates the forwarded bit clock itself and places every data transition on that clock's rising edge, half a bit period after its falling edge. The receiver can then capture data on the falling edge with wide margin. A length code of 255 is reserved, and the block discards it.

Top module: `sync_frame_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, `ser_data` is 0. After reset `in_ready` is 1 and `busy` and `rej_pulse` are 0.
- R2: Each character is, in line order: a start bit of 1, data bits 0 through 7 (least significant first), a parity bit that makes the number of ones in data plus parity even, and a stop bit of 0.
- R3: For a length code N from 1 to 254, the frame carries N+2 characters: the code, the command byte, N-1 payload bytes in the order accepted, then the CRC. The block accepts exactly N bytes after the code.
- R4: A length code of 0 produces exactly two characters, the code and the CRC, and the block accepts no further bytes for that frame.
- R5: A length code of 255 offered while idle is consumed. It raises `rej_pulse` for exactly one cycle, leaves `busy` low and puts no character on the line.
- R6: The CRC character equals CRC8 with polynomial 0x07 and initial value 0x00, fed most significant bit first with every byte of the frame that precedes it.
- R7: `fwd_clk` toggles on every `clk` edge, so one bit lasts two `clk` cycles. `ser_data` changes only on edges where `fwd_clk` goes from 0 to 1.
- R8: `busy` rises on the edge that accepts a valid length code. It is still high while the CRC stop bit is on the line and falls on the bit edge that ends that stop bit.
- R9: When the source keeps a byte ready, characters within a frame follow each other with no idle bit between them. When the source stalls, only low idle bits are inserted and the frame content is unchanged.
- R10: `in_ready` is low from the acceptance of the last byte a frame needs until `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the line bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source offers a byte |
| in_data | input | 8 | Offered byte (length code first, then command and payload) |
| in_ready | output | 1 | Block accepts the offered byte on this edge |
| busy | output | 1 | Frame in progress |
| rej_pulse | output | 1 | One-cycle pulse when a reserved length code is discarded |
| ser_data | output | 1 | Serial data line |
| fwd_clk | output | 1 | Forwarded bit clock |

## Verification
The hardest situation to reach is a source that falls behind in the middle of a frame. The holding register is then empty when the serializer's slot opens, but bytes are still owed, so the frame must neither end early nor release `busy`. The bench produces this by stalling for longer than one character time before chosen payload bytes. It then checks that only low idle bits appear and that the decoded bytes and CRC still match. The bench sweeps frame lengths from 0 to 12 and also the two largest legal lengths, so the zero-length case and the full 253-byte payload are both covered.

// File: rtl/sft_pkg.sv
package sft_pkg;
    localparam int BYTE_W = 8;
    localparam int CHAR_W = BYTE_W + 3;
    localparam int CNT_W  = $clog2(CHAR_W);

    typedef logic [BYTE_W-1:0] byte_t;

    // CRC over one byte, MSB first, non-reflected
    function automatic byte_t crc8_step(byte_t crc, byte_t din, byte_t poly);
        byte_t c;
        c = crc ^ din;
        for (int i = 0; i < BYTE_W; i++) begin
            c = c[BYTE_W-1] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/sft_bitclk.sv
module sft_bitclk (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic fwd_clk
);
    typedef struct packed {
        logic ph;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = ~st_q.ph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // data advances on the edge where the forwarded clock rises
    assign tick    = ~st_q.ph;
    assign fwd_clk = st_q.ph;

    assert_fwd_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fwd_clk != $past(fwd_clk)));
endmodule

// File: rtl/sft_serializer.sv
module sft_serializer
    import sft_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  ld_valid,
    input  byte_t ld_byte,
    output logic  ld_ack,
    output logic  slot_free,
    output logic  line
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [CHAR_W-2:0] sh;
        logic              line;
    } st_t;

    st_t st_d, st_q;

    assign slot_free = tick && (!st_q.active || st_q.cnt == LAST);
    assign ld_ack    = slot_free && ld_valid;
    assign line      = st_q.line;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (st_q.active && st_q.cnt != LAST) begin
                st_d.line = st_q.sh[0];
                st_d.sh   = st_q.sh >> 1;
                st_d.cnt  = st_q.cnt + 1'b1;
            end else if (ld_valid) begin
                st_d.active = 1'b1;
                st_d.cnt    = '0;
                st_d.line   = 1'b1;
                st_d.sh     = {1'b0, ^ld_byte, ld_byte};
            end else begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
                st_d.line   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_start_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ack |=> line);
    assert_stop_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.cnt == LAST) |-> !line);
endmodule

// File: rtl/sync_frame_tx.sv
module sync_frame_tx
    import sft_pkg::*;
#(
    parameter int          MAX_LEN  = 254,
    parameter logic [7:0]  CRC_POLY = 8'h07
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       busy,
    output logic       rej_pulse,
    output logic       ser_data,
    output logic       fwd_clk
);
    localparam byte_t MAX_B = byte_t'(MAX_LEN);

    typedef struct packed {
        logic  busy;
        logic  hold_vld;
        byte_t hold;
        byte_t rem;
        byte_t crc;
        logic  crc_pend;
        logic  rej;
    } st_t;

    st_t   st_d, st_q;
    logic  tick, ld_valid, ld_ack, slot_free, accept;
    byte_t ld_byte;

    sft_bitclk u_bitclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .fwd_clk (fwd_clk)
    );

    sft_serializer u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ld_valid  (ld_valid),
        .ld_byte   (ld_byte),
        .ld_ack    (ld_ack),
        .slot_free (slot_free),
        .line      (ser_data)
    );

    assign in_ready  = !st_q.hold_vld && (st_q.busy ? (st_q.rem != '0) : 1'b1);
    assign accept    = in_valid && in_ready;
    assign ld_valid  = st_q.hold_vld || (st_q.busy && st_q.rem == '0 && st_q.crc_pend);
    assign ld_byte   = st_q.hold_vld ? st_q.hold : st_q.crc;
    assign busy      = st_q.busy;
    assign rej_pulse = st_q.rej;

    always_comb begin
        st_d     = st_q;
        st_d.rej = 1'b0;
        if (ld_ack) begin
            if (st_q.hold_vld) st_d.hold_vld = 1'b0;
            else               st_d.crc_pend = 1'b0;
        end else if (slot_free && st_q.busy && !st_q.hold_vld &&
                     st_q.rem == '0 && !st_q.crc_pend) begin
            st_d.busy = 1'b0;
        end
        if (accept) begin
            if (!st_q.busy) begin
                if (in_data > MAX_B) begin
                    st_d.rej = 1'b1;
                end else begin
                    st_d.busy     = 1'b1;
                    st_d.hold     = in_data;
                    st_d.hold_vld = 1'b1;
                    st_d.rem      = in_data;
                    st_d.crc      = crc8_step('0, in_data, CRC_POLY);
                    st_d.crc_pend = 1'b1;
                end
            end else begin
                st_d.hold     = in_data;
                st_d.hold_vld = 1'b1;
                st_d.rem      = st_q.rem - 1'b1;
                st_d.crc      = crc8_step(st_q.crc, in_data, CRC_POLY);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_idle_line_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ser_data);
    assert_reserved_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !busy && in_data > MAX_B) |=> (!busy && rej_pulse));
    assert_busy_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !busy && in_data <= MAX_B) |=> busy);
    assert_edge_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (ser_data != $past(ser_data)) |-> (fwd_clk && !$past(fwd_clk)));
endmodule

// File: tb/sync_frame_tx_bench.sv
module sync_frame_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, busy, rej_pulse, ser_data, fwd_clk;

    int n_chk = 0;
    int n_bad = 0;

    sync_frame_tx u_sync_frame_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .busy(busy), .rej_pulse(rej_pulse),
        .ser_data(ser_data), .fwd_clk(fwd_clk)
    );

    always #4 clk = ~clk;

    // receiver / monitor state
    logic [7:0] rx_buf [0:299];
    logic [7:0] exp_buf [0:299];
    int   rx_cnt = 0, gap_cnt = 0, par_err = 0, stop_err = 0, starts = 0;
    int   phase_err = 0, toggle_err = 0, rej_cnt = 0, busy_seen = 0;
    int   r_bit = 0;
    logic [7:0] r_sh = 8'h00;
    logic r_par = 1'b0;
    logic stop_busy = 1'b0, after_busy = 1'b1, after_pend = 1'b0;
    logic fwd_prev = 1'b0, ser_prev = 1'b0, mon_on = 1'b0;

    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            if (fwd_clk == fwd_prev) toggle_err++;
            if (ser_data != ser_prev && !(fwd_clk && !fwd_prev)) phase_err++;
            if (rej_pulse) rej_cnt++;
            if (busy) busy_seen++;
            if (fwd_clk && !fwd_prev) begin
                if (after_pend) begin after_busy = busy; after_pend = 1'b0; end
                if (r_bit == 0) begin
                    if (ser_data) begin r_bit = 1; r_sh = 8'h00; starts++; end
                    else if (busy && rx_cnt > 0) gap_cnt++;
                end else if (r_bit <= 8) begin
                    r_sh[r_bit-1] = ser_data; r_bit++;
                end else if (r_bit == 9) begin
                    r_par = ser_data; r_bit = 10;
                end else begin
                    if (ser_data !== 1'b0) stop_err++;
                    if (r_par !== ^r_sh) par_err++;
                    if (rx_cnt < 300) rx_buf[rx_cnt] = r_sh;
                    rx_cnt++;
                    stop_busy = busy; after_pend = 1'b1; r_bit = 0;
                end
            end
        end
        fwd_prev = fwd_clk;
        ser_prev = ser_data;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [7:0] ref_crc(input int n);
        logic [7:0] c = 8'h00;
        for (int k = 0; k < n; k++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb;
                fb = c[7] ^ exp_buf[k][b];
                c  = {c[6:0], 1'b0};
                if (fb) c = c ^ 8'h07;
            end
        end
        return c;
    endfunction

    task automatic push_byte(input logic [7:0] b, input int stall);
        repeat (stall) @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        forever begin
            if (in_ready) begin
                @(posedge clk);
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic run_frame(input int len, input int seed, input bit stall);
        int n;
        int bad_bytes;
        int ready_leak;
        n = (len == 0) ? 2 : len + 2;
        exp_buf[0] = 8'(len);
        for (int k = 1; k <= len; k++) exp_buf[k] = 8'((seed * 37 + k * 91 + 13) & 255);
        exp_buf[n-1] = ref_crc(n - 1);
        rx_cnt = 0; gap_cnt = 0; par_err = 0; stop_err = 0; after_busy = 1'b1;
        push_byte(8'(len), 0);
        chk(busy == 1'b1, "R8 busy after length", int'(busy), 1);
        for (int k = 1; k <= len; k++)
            push_byte(exp_buf[k], (stall && (k % 3 == 1)) ? 30 : 0);
        ready_leak = 0;
        while (busy) begin
            if (in_ready) ready_leak++;
            @(negedge clk);
        end
        repeat (6) @(negedge clk);
        chk(ready_leak == 0, "R10 ready closed", ready_leak, 0);
        chk(rx_cnt == n, (len == 0) ? "R4 char count" : "R3 char count", rx_cnt, n);
        bad_bytes = 0;
        for (int k = 0; k < n - 1 && k < rx_cnt; k++)
            if (rx_buf[k] !== exp_buf[k]) bad_bytes++;
        chk(bad_bytes == 0, "R3 frame bytes", bad_bytes, 0);
        if (rx_cnt >= n)
            chk(rx_buf[n-1] === exp_buf[n-1], "R6 crc", int'(rx_buf[n-1]), int'(exp_buf[n-1]));
        else
            chk(1'b0, "R6 crc missing", rx_cnt, n);
        chk(par_err == 0 && stop_err == 0, "R2 parity/stop", par_err + stop_err, 0);
        if (!stall) chk(gap_cnt == 0, "R9 back to back", gap_cnt, 0);
        else        chk(gap_cnt > 0, "R9 stall idles", gap_cnt, 1);
        chk(stop_busy == 1'b1 && after_busy == 1'b0, "R8 busy end",
            int'({stop_busy, after_busy}), 2);
        chk(ser_data == 1'b0, "R1 idle low", int'(ser_data), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        chk(ser_data == 1'b0 && busy == 1'b0 && rej_pulse == 1'b0, "R1 reset state",
            int'({ser_data, busy, rej_pulse}), 0);
        chk(in_ready == 1'b1, "R10 ready at reset", int'(in_ready), 1);

        for (int len = 0; len <= 12; len++) run_frame(len, len + 3, 1'b0);
        run_frame(5, 77, 1'b1);
        run_frame(9, 21, 1'b1);
        run_frame(253, 5, 1'b0);
        run_frame(254, 11, 1'b0);

        // reserved length code
        rej_cnt = 0; busy_seen = 0; starts = 0;
        push_byte(8'd255, 0);
        repeat (60) @(negedge clk);
        chk(rej_cnt == 1, "R5 reject pulse", rej_cnt, 1);
        chk(busy_seen == 0, "R5 busy stays low", busy_seen, 0);
        chk(starts == 0, "R5 no line activity", starts, 0);
        run_frame(3, 99, 1'b0);

        chk(phase_err == 0, "R7 edge alignment", phase_err, 0);
        chk(toggle_err == 0, "R7 clock toggles", toggle_err, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule